// File: doc/BRIEF.md
# Oscillator Start-Up Settle Timer

This block decides when a freshly restarted oscillator may be trusted. A stop request turns the oscillator off and reloads a down-counter with its largest value (all ones). When the request is withdrawn, the block turns the oscillator on again. The counter then steps down once for every cycle in which the oscillator reports a running tick. When the counter reaches zero it stays there and the block raises a clock-good flag. Logic downstream waits for that flag before it uses the clock.

The counter width is a parameter. A width of 14 gives a preset of 3FFFh, which suits a fast crystal. A width of 6 gives a preset of 3Fh, which suits a slow crystal. The analog oscillator is not modelled. A tick input stands in for it: the tick is high on the cycles in which the oscillator has produced a usable edge. Reset is synchronous and active low.

Top module: `osc_settle_timer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block enters the stopped state. After that edge, `osc_en` and `clk_good` are low, and the counter holds its all-ones preset.
- R2: In any cycle where `stop_req` is high, `osc_en` and `clk_good` are both low.
- R3: When `stop_req` has been sampled low at a rising edge, `osc_en` is high in the following cycle, provided `stop_req` is still low in that cycle.
- R4: Only cycles with `osc_en` high and `osc_tick` high move the count. Cycles with `osc_tick` low leave the remaining count unchanged.
- R5: `clk_good` rises in the cycle after the edge that carries the 2^WIDTH−1-th counted tick since the last reload. It stays high for any further ticks while `stop_req` stays low, because the counter holds at zero and does not wrap.
- R6: `clk_good` goes low combinationally in the same cycle that `stop_req` rises.
- R7: If `stop_req` rises in the middle of a count, the counter reloads its full preset and keeps no partial progress. After the release, a further 2^WIDTH−1 counted ticks are needed.
- R8: With WIDTH=6, the preset is 3Fh, so 63 counted ticks are needed. With the default WIDTH=14, the preset is 3FFFh, so 16383 counted ticks are needed.
- R9: A stop request issued after `clk_good` is high starts a full new settle period once it is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req | input | 1 | Request to halt the oscillator and reload the counter |
| osc_tick | input | 1 | High on cycles where the oscillator delivers a running tick |
| osc_en | output | 1 | Oscillator enable; low means the oscillator is held off |
| clk_good | output | 1 | High once the settle count has fully elapsed |

## Verification
A fast instance and a slow instance receive the same stimulus, so one sequence tests both widths. Several tick patterns are used:
- A continuous tick checks the exact count against the preset.
- An alternating tick shows that idle cycles give no credit.
- A long run with the tick held low shows that the count freezes.

Several stop-request patterns are also used:
- A stop in the middle of a count, released before the slow instance finishes, separates a true reload from a pause.
- A one-cycle stop while the flag is already high checks the same-cycle drop of the flag and the full restart afterwards.
- A reset asserted during a count checks the return to the preset.

// File: rtl/ost_pkg.sv
`timescale 1ns/1ps
// Shared types for the oscillator settle timer.
package ost_pkg;

    // Control phases of the settle sequence.
    typedef enum logic [1:0] {
        OST_STOPPED  = 2'd0,
        OST_COUNTING = 2'd1,
        OST_STABLE   = 2'd2
    } ost_state_t;

endpackage

// File: rtl/ost_down_counter.sv
`timescale 1ns/1ps
// Loadable saturating down-counter.
// Function: a load reloads all ones; a decrement request steps the count
// down by one; the count stops at zero and never wraps.
// Assumes: load takes priority over decrement; reset is synchronous, active low.
module ost_down_counter #(
    parameter int WIDTH = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             dec_i,
    output logic [WIDTH-1:0] count_o,
    output logic             zero_o
);
    localparam logic [WIDTH-1:0] PRESET = {WIDTH{1'b1}};

    logic [WIDTH-1:0] cnt_q;

    // Count register: reload, step down, or hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= PRESET;
        end else if (load_i) begin
            cnt_q <= PRESET;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Zero detect for the control logic.
    always_comb begin
        zero_o  = (cnt_q == '0);
        count_o = cnt_q;
    end
endmodule

// File: rtl/ost_ctrl.sv
`timescale 1ns/1ps
// Settle sequence controller.
// Function: tracks the stopped, counting and stable phases. It issues reload
// and decrement requests to the counter and drives the enable and good
// outputs.
// Assumes: stop_req_i is synchronous to clk. The outputs react to stop_req_i
// combinationally, so both drop in the same cycle as the request.
module ost_ctrl
    import ost_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req_i,
    input  logic tick_i,
    input  logic zero_i,
    output logic load_o,
    output logic dec_o,
    output logic osc_en_o,
    output logic good_o
);
    ost_state_t state_q;
    ost_state_t state_d;

    // Next-phase selection; a stop request always returns to the stopped phase.
    always_comb begin
        state_d = state_q;
        if (stop_req_i) begin
            state_d = OST_STOPPED;
        end else begin
            unique case (state_q)
                OST_STOPPED:  state_d = OST_COUNTING;
                OST_COUNTING: state_d = zero_i ? OST_STABLE : OST_COUNTING;
                OST_STABLE:   state_d = OST_STABLE;
                default:      state_d = OST_STOPPED;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OST_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode from the phase and the live stop request.
    always_comb begin
        load_o   = stop_req_i || (state_q == OST_STOPPED);
        dec_o    = (state_q == OST_COUNTING) && !stop_req_i && tick_i;
        osc_en_o = (state_q != OST_STOPPED) && !stop_req_i;
        good_o   = (state_q != OST_STOPPED) && !stop_req_i && zero_i;
    end
endmodule

// File: rtl/osc_settle_timer.sv
`timescale 1ns/1ps
// Oscillator start-up settle timer (top).
// Function: holds the oscillator off and the count at its preset while a
// stop is requested. After the release it counts oscillator ticks down to
// zero, then flags the clock as good.
// Assumes: osc_tick is a synchronous qualifier standing in for the oscillator.
module osc_settle_timer #(
    parameter int WIDTH = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic osc_tick,
    output logic osc_en,
    output logic clk_good
);
    logic             load;
    logic             dec;
    logic             zero;
    logic [WIDTH-1:0] count;

    // Phase controller.
    ost_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_req_i (stop_req),
        .tick_i     (osc_tick),
        .zero_i     (zero),
        .load_o     (load),
        .dec_o      (dec),
        .osc_en_o   (osc_en),
        .good_o     (clk_good)
    );

    // Settle counter.
    ost_down_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .dec_i   (dec),
        .count_o (count),
        .zero_o  (zero)
    );
endmodule

// File: rtl/osc_settle_timer_chk.sv
`timescale 1ns/1ps
// Property checker for osc_settle_timer. It is attached through bind and
// keeps an independent count of the ticks credited since the last reload.
module osc_settle_timer_chk #(
    parameter int WIDTH = 14
) (
    input logic clk,
    input logic rst_n,
    input logic stop_req,
    input logic osc_tick,
    input logic osc_en,
    input logic clk_good
);
    localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};

    logic [WIDTH-1:0] seen_q;

    // Credited ticks since the oscillator was last enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !osc_en) begin
            seen_q <= '0;
        end else if (osc_tick && (seen_q != FULL)) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> (!osc_en && !clk_good)); // R2

    AST_EN_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_req |=> (stop_req || osc_en)); // R3

    AST_GOOD_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        clk_good |-> (seen_q == FULL)); // R4

    AST_GOOD_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && (seen_q == FULL)) |-> clk_good); // R5

    AST_GOOD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_good |=> (stop_req || clk_good)); // R5

    AST_GOOD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        clk_good |-> osc_en); // R6
endmodule

bind osc_settle_timer osc_settle_timer_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_req (stop_req),
    .osc_tick (osc_tick),
    .osc_en   (osc_en),
    .clk_good (clk_good)
);

// File: tb/osc_settle_timer_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes each cycle's expected outputs from
// a behavioural model and queues them; the monitor compares mid-cycle.
module osc_settle_timer_test;
    localparam int WH = 14;
    localparam int WL = 6;
    localparam int PH = (1 << WH) - 1;
    localparam int PL = (1 << WL) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 1'b0;
    logic osc_tick = 1'b0;
    logic en_h, good_h, en_l, good_l;

    always #4 clk = ~clk;

    osc_settle_timer uut (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .osc_tick(osc_tick),
        .osc_en(en_h), .clk_good(good_h)
    );

    osc_settle_timer #(.WIDTH(WL)) uut_lf (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .osc_tick(osc_tick),
        .osc_en(en_l), .clk_good(good_l)
    );

    typedef struct {
        logic  eh, gh, el, gl;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    // Behavioural model state
    bit m_valid = 1'b0;
    bit m_run_h, m_run_l;
    int m_cnt_h, m_cnt_l;

    // Drive one cycle, queue its expected outputs, advance the model.
    task automatic step(input logic req, input logic tk, input logic rv, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = rv; stop_req = req; osc_tick = tk;
        if (m_valid) begin
            e.eh  = m_run_h && !req;
            e.gh  = m_run_h && !req && (m_cnt_h == 0);
            e.el  = m_run_l && !req;
            e.gl  = m_run_l && !req && (m_cnt_l == 0);
            e.tag = tag;
            q.push_back(e);
        end
        if (!rv) begin
            m_run_h = 0; m_run_l = 0; m_cnt_h = PH; m_cnt_l = PL; m_valid = 1'b1;
        end else begin
            if (req || !m_run_h) m_cnt_h = PH;
            else if (tk && m_cnt_h != 0) m_cnt_h--;
            if (req || !m_run_l) m_cnt_l = PL;
            else if (tk && m_cnt_l != 0) m_cnt_l--;
            m_run_h = !req;
            m_run_l = !req;
        end
    endtask

    task automatic run(input int n, input logic req, input int pat, input string tag);
        for (int i = 0; i < n; i++) begin
            logic tk;
            tk = (pat == 1) ? 1'b1 : (pat == 2) ? logic'(i % 2) : 1'b0;
            step(req, tk, 1'b1, tag);
        end
    endtask

    // Monitor: pop and compare in the middle of each low phase.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if ({en_h, good_h, en_l, good_l} !== {e.eh, e.gh, e.el, e.gl}) begin
                    errors++;
                    $display("FAIL %s: got en_h=%b good_h=%b en_l=%b good_l=%b expected %b %b %b %b",
                             e.tag, en_h, good_h, en_l, good_l, e.eh, e.gh, e.el, e.gl);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, "R1 reset");
        run(5, 1'b1, 1, "R2 stop held");
        run(40, 1'b0, 1, "R3 R4 first count");
        run(2, 1'b1, 1, "R7 mid-count stop");
        run(140, 1'b0, 2, "R4 R8 alternating ticks");
        run(50, 1'b0, 0, "R4 tick idle");
        run(PH + 10, 1'b0, 1, "R5 R8 full count");
        run(30, 1'b0, 2, "R5 hold at zero");
        run(1, 1'b1, 1, "R6 stop while good");
        run(70, 1'b0, 1, "R9 restart");
        run(1000, 1'b0, 1, "R5 R9 wide restart");
        step(1'b0, 1'b1, 1'b0, "R1 reset mid count");
        step(1'b0, 1'b1, 1'b0, "R1 reset mid count");
        run(80, 1'b0, 1, "R1 R8 after reset");
        @(negedge clk);
        #3;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule